// File: doc/BRIEF.md
# Tag-Synchronized Quadrature Down-Mixer

This block takes a stream of signed 14-bit converter samples, one per clock, and multiplies each by a cosine and a sine from a local oscillator. The result is a pair of 15-bit baseband components, I and Q, with a valid strobe. The oscillator is a 32-bit phase accumulator that drives a quarter-wave sine table. Its step equals a base frequency word times an integer harmonic, so the oscillator runs at a programmable multiple of the reference that the tags mark.

A tag pulse returns the oscillator phase to zero, which keeps the mixer aligned to the tagged reference. Software writes the frequency word and the harmonic into staging registers over a small write-only bus. The staged values reach the running oscillator only when a double-tag strobe arrives, so the harmonic can be changed during operation without a phase glitch between tags.

A two-state machine tracks the staging registers. In `LO_SYNCED` the staged step already equals the active step. A register write moves the machine to `LO_PENDING` (transition *stage*). A double-tag with no write in the same cycle moves it back to `LO_SYNCED` (transition *commit*). A double-tag that coincides with a write leaves or puts the machine in `LO_PENDING` (transition *commit-and-restage*).

Top module: `quad_downmix`

## Requirements
- R1: After reset, `out_valid`, `i_out` and `q_out` are zero. The staged word is 0 and the staged harmonic is 1, so the active phase step is 0.
- R2: A write with `reg_addr`=0 stages the 32-bit frequency word. A write with `reg_addr`=1 stages the harmonic from `reg_wdata[7:0]`. Staged values have no effect on the oscillator until a double-tag.
- R3: In each cycle the phase equals the previous phase plus the active step, modulo 2^32. In a cycle with `tag` high, the phase is 0 for that cycle's sample.
- R4: In a cycle with `dtag` high, the active step becomes (word × harmonic) mod 2^32, and the phase advance in that same cycle already uses it. A register write in the dtag cycle is not part of that commit.
- R5: When `tag` and `dtag` are high in the same cycle, that cycle's phase is 0, and the following advances use the newly committed step.
- R6: The table index p is phase[31:22]. The sine value is round(32767·sin(2π(p+0.5)/1024)), and the cosine value is the sine value at index (p+256) mod 1024.
- R7: I = sat(round(x·cos/2^14)) and Q = sat(round(x·sin/2^14)), where x is the signed sample. Rounding is half up and saturation is to [-16384, 16383]. The value -16384 never appears.
- R8: Results appear 3 clock cycles after the cycle in which their sample is presented. `out_valid` is `adc_valid` delayed by 3 cycles.
- R9: If `chan_en` is low in a sample's cycle, that sample's I and Q are both 0.
- R10: The phase advances every clock, whether `adc_valid` is high or low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adc_data | input | 14 | Signed converter sample |
| adc_valid | input | 1 | Sample qualifier |
| tag | input | 1 | Phase realignment pulse |
| dtag | input | 1 | Double-tag commit strobe |
| chan_en | input | 1 | Channel enable; low forces zero outputs |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = frequency word, 1 = harmonic |
| reg_wdata | input | 32 | Register write data |
| i_out | output | 15 | In-phase result, signed |
| q_out | output | 15 | Quadrature result, signed |
| out_valid | output | 1 | Result qualifier |

## Verification
Every sample result, including its valid bit and the enable gating, is due exactly three rising edges after the falling edge on which the sample is driven. The bench holds a three-deep queue of expected results and compares the oldest entry at each falling edge before it drives the next inputs. Tag, double-tag and register writes take effect on the phase of the cycle in which they are driven. The bench's oscillator model therefore updates in the same step as the stimulus, and their effect shows up in the outputs three cycles later through the same queue.

// File: rtl/qdm_pkg.sv
package qdm_pkg;
    typedef enum logic [0:0] {
        LO_SYNCED  = 1'b0,
        LO_PENDING = 1'b1
    } lo_state_e;

    localparam logic REG_FREQ = 1'b0;
    localparam logic REG_HARM = 1'b1;
endpackage

// File: rtl/qdm_lo_ctrl.sv
module qdm_lo_ctrl
    import qdm_pkg::*;
#(
    parameter int PHASE_W = 32,
    parameter int HARM_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_addr,
    input  logic [PHASE_W-1:0] wr_data,
    input  logic               dtag,
    output logic [PHASE_W-1:0] inc_eff
);
    logic [PHASE_W-1:0] stg_word_q;
    logic [HARM_W-1:0]  stg_harm_q;
    logic [PHASE_W-1:0] act_inc_q;
    logic [PHASE_W-1:0] staged_inc;
    lo_state_e          state_q, state_d;

    always_comb staged_inc = stg_word_q * PHASE_W'(stg_harm_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LO_SYNCED;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LO_SYNCED:  if (wr_en) state_d = LO_PENDING;
            LO_PENDING: if (dtag && !wr_en) state_d = LO_SYNCED;
            default:    state_d = LO_SYNCED;
        endcase
    end

    // staging and active parameters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_word_q <= '0;
            stg_harm_q <= HARM_W'(1);
            act_inc_q  <= '0;
        end else begin
            if (dtag) act_inc_q <= staged_inc;
            if (wr_en && wr_addr == REG_FREQ) stg_word_q <= wr_data;
            if (wr_en && wr_addr == REG_HARM) stg_harm_q <= wr_data[HARM_W-1:0];
        end
    end

    // output: committed step applies in the strobe cycle itself
    always_comb inc_eff = dtag ? staged_inc : act_inc_q;

    a_r4_synced_match: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == LO_SYNCED |-> act_inc_q == staged_inc);
    a_r4_commit: assert property (@(posedge clk) disable iff (!rst_n)
        dtag |=> act_inc_q == $past(staged_inc));
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dtag |=> $stable(act_inc_q));
endmodule

// File: rtl/qdm_phase_acc.sv
module qdm_phase_acc #(
    parameter int PHASE_W = 32,
    parameter int ADDR_W  = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tag,
    input  logic [PHASE_W-1:0] inc,
    output logic [ADDR_W-1:0]  lut_idx
);
    logic [PHASE_W-1:0] acc_q;
    logic [PHASE_W-1:0] ph_now;

    always_comb begin
        ph_now  = tag ? '0 : acc_q + inc;
        lut_idx = ph_now[PHASE_W-1 -: ADDR_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= ph_now;
    end

    a_r3_tag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        tag |=> acc_q == '0);
    a_r10_advance: assert property (@(posedge clk) disable iff (!rst_n)
        !tag |=> acc_q == $past(acc_q) + $past(inc));
endmodule

// File: rtl/qdm_sine_lut.sv
module qdm_sine_lut #(
    parameter int ADDR_W = 10,
    parameter int LO_W   = 16
) (
    input  logic [ADDR_W-1:0]      idx,
    output logic signed [LO_W-1:0] sin_v,
    output logic signed [LO_W-1:0] cos_v
);
    localparam int  QBITS = ADDR_W - 2;
    localparam int  QN    = 1 << QBITS;
    localparam real AMP   = real'((1 << (LO_W - 1)) - 1);
    localparam real TWOPI = 6.283185307179586;

    logic signed [LO_W-1:0] qtab [QN];

    for (genvar q = 0; q < QN; q++) begin : g_tab
        localparam real ANG = TWOPI * (real'(q) + 0.5) / real'(4 * QN);
        localparam int  VAL = $rtoi(AMP * $sin(ANG) + 0.5);
        assign qtab[q] = LO_W'(VAL);
    end

    // k = 0 sine, k = 1 cosine (quarter-turn offset)
    for (genvar k = 0; k < 2; k++) begin : g_ph
        logic [ADDR_W-1:0]      a;
        logic [QBITS-1:0]       m;
        logic signed [LO_W-1:0] mag;
        logic signed [LO_W-1:0] val;
        always_comb begin
            a   = idx + ADDR_W'(k * QN);
            m   = a[ADDR_W-2] ? ~a[QBITS-1:0] : a[QBITS-1:0];
            mag = qtab[m];
            val = a[ADDR_W-1] ? -mag : mag;
        end
    end

    assign sin_v = g_ph[0].val;
    assign cos_v = g_ph[1].val;
endmodule

// File: rtl/qdm_mixer.sv
module qdm_mixer #(
    parameter int IN_W  = 14,
    parameter int LO_W  = 16,
    parameter int OUT_W = 15
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic signed [IN_W-1:0]  x,
    input  logic signed [LO_W-1:0]  lo,
    output logic signed [OUT_W-1:0] y
);
    localparam int PROD_W = IN_W + LO_W;
    localparam int SHIFT  = LO_W - 2;
    localparam logic signed [PROD_W:0] HALF = (PROD_W+1)'(1) <<< (SHIFT - 1);
    localparam logic signed [PROD_W:0] MAXV = (PROD_W+1)'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [PROD_W:0] MINV = -MAXV - (PROD_W+1)'(1);

    logic signed [PROD_W-1:0] prod_q;
    logic                     en_q;
    logic signed [PROD_W:0]   rnd;
    logic signed [PROD_W:0]   shifted;
    logic signed [OUT_W-1:0]  sat;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q <= '0;
            en_q   <= 1'b0;
        end else begin
            prod_q <= x * lo;
            en_q   <= en;
        end
    end

    always_comb begin
        rnd     = (PROD_W+1)'(prod_q) + HALF;
        shifted = rnd >>> SHIFT;
        if (shifted > MAXV)      sat = MAXV[OUT_W-1:0];
        else if (shifted < MINV) sat = MINV[OUT_W-1:0];
        else                     sat = shifted[OUT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) y <= '0;
        else        y <= en_q ? sat : '0;
    end

    a_r7_no_full_negative: assert property (@(posedge clk) disable iff (!rst_n)
        y != $signed({1'b1, {(OUT_W-1){1'b0}}}));
endmodule

// File: rtl/quad_downmix.sv
module quad_downmix
    import qdm_pkg::*;
#(
    parameter int IN_W    = 14,
    parameter int OUT_W   = 15,
    parameter int PHASE_W = 32,
    parameter int HARM_W  = 8,
    parameter int ADDR_W  = 10,
    parameter int LO_W    = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [IN_W-1:0]         adc_data,
    input  logic                    adc_valid,
    input  logic                    tag,
    input  logic                    dtag,
    input  logic                    chan_en,
    input  logic                    reg_wr,
    input  logic                    reg_addr,
    input  logic [PHASE_W-1:0]      reg_wdata,
    output logic signed [OUT_W-1:0] i_out,
    output logic signed [OUT_W-1:0] q_out,
    output logic                    out_valid
);
    logic [PHASE_W-1:0]     inc_eff;
    logic [ADDR_W-1:0]      lut_idx;
    logic signed [LO_W-1:0] sin_c, cos_c;
    logic signed [IN_W-1:0] x_s1;
    logic signed [LO_W-1:0] lo_s1 [2];
    logic                   en_s1, vld_s1, vld_s2, vld_s3;

    qdm_lo_ctrl #(.PHASE_W(PHASE_W), .HARM_W(HARM_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_addr),
        .wr_data(reg_wdata), .dtag(dtag), .inc_eff(inc_eff)
    );

    qdm_phase_acc #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .tag(tag), .inc(inc_eff), .lut_idx(lut_idx)
    );

    qdm_sine_lut #(.ADDR_W(ADDR_W), .LO_W(LO_W)) u_lut (
        .idx(lut_idx), .sin_v(sin_c), .cos_v(cos_c)
    );

    // stage 1: sample and oscillator values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_s1     <= '0;
            lo_s1[0] <= '0;
            lo_s1[1] <= '0;
            en_s1    <= 1'b0;
            vld_s1   <= 1'b0;
            vld_s2   <= 1'b0;
            vld_s3   <= 1'b0;
        end else begin
            x_s1     <= $signed(adc_data);
            lo_s1[0] <= cos_c;
            lo_s1[1] <= sin_c;
            en_s1    <= chan_en;
            vld_s1   <= adc_valid;
            vld_s2   <= vld_s1;
            vld_s3   <= vld_s2;
        end
    end

    // stages 2 and 3: k = 0 in-phase, k = 1 quadrature
    for (genvar k = 0; k < 2; k++) begin : g_mix
        logic signed [OUT_W-1:0] y;
        qdm_mixer #(.IN_W(IN_W), .LO_W(LO_W), .OUT_W(OUT_W)) u_mix (
            .clk(clk), .rst_n(rst_n), .en(en_s1), .x(x_s1), .lo(lo_s1[k]), .y(y)
        );
    end

    assign i_out     = g_mix[0].y;
    assign q_out     = g_mix[1].y;
    assign out_valid = vld_s3;

    // cycles since reset, saturating at the pipeline depth
    logic [1:0] rst_age;
    always_ff @(posedge clk) begin
        if (!rst_n)              rst_age <= '0;
        else if (rst_age != 2'd3) rst_age <= rst_age + 2'd1;
    end

    a_r8_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        rst_age == 2'd3 |-> out_valid == $past(adc_valid, 3));
    a_r9_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_age == 2'd3 && !$past(chan_en, 3)) |-> (i_out == '0 && q_out == '0));
    a_r1_reset_quiet: assert property (@(posedge clk)
        !$past(rst_n) |-> (!out_valid && i_out == '0 && q_out == '0));
endmodule

// File: tb/tb_quad_downmix.sv
module tb_quad_downmix;
    timeunit 1ns;
    timeprecision 1ps;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [13:0]        adc_data = '0;
    logic               adc_valid = 1'b0;
    logic               tag = 1'b0;
    logic               dtag = 1'b0;
    logic               chan_en = 1'b0;
    logic               reg_wr = 1'b0;
    logic               reg_addr = 1'b0;
    logic [31:0]        reg_wdata = '0;
    logic signed [14:0] i_out, q_out;
    logic               out_valid;

    quad_downmix dut (
        .clk(clk), .rst_n(rst_n), .adc_data(adc_data), .adc_valid(adc_valid),
        .tag(tag), .dtag(dtag), .chan_en(chan_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .i_out(i_out), .q_out(q_out), .out_valid(out_valid)
    );

    always #4 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    // bench oscillator model
    logic [31:0] m_acc, m_act, m_word;
    logic [7:0]  m_harm;
    int          e_i [3];
    int          e_q [3];
    bit          e_v [3];

    localparam real PI2 = 6.283185307179586;

    function automatic int lo_sin(int p);
        real v = 32767.0 * $sin(PI2 * (real'(p) + 0.5) / 1024.0);
        return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
    endfunction

    function automatic int mix(int x, int lo);
        longint pr = longint'(x) * longint'(lo);
        longint r  = (pr + 64'sd8192) >>> 14;
        if (r > 16383)  r = 16383;
        if (r < -16384) r = -16384;
        return int'(r);
    endfunction

    task automatic check(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    task automatic cyc(int x, bit v, bit tg, bit dt, bit en, bit wr, bit ad, logic [31:0] wd);
        logic [31:0] ph;
        int p;
        @(negedge clk);
        check("valid", int'(out_valid), int'(e_v[2]));
        if (e_v[2]) begin
            check("I", int'(i_out), e_i[2]);
            check("Q", int'(q_out), e_q[2]);
        end
        adc_data  = x[13:0];
        adc_valid = v;
        tag       = tg;
        dtag      = dt;
        chan_en   = en;
        reg_wr    = wr;
        reg_addr  = ad;
        reg_wdata = wd;
        if (dt) m_act = m_word * {24'd0, m_harm};
        ph    = tg ? 32'd0 : m_acc + m_act;
        m_acc = ph;
        if (wr && !ad) m_word = wd;
        if (wr && ad)  m_harm = wd[7:0];
        p = int'(ph[31:22]);
        for (int k = 2; k > 0; k--) begin
            e_i[k] = e_i[k-1];
            e_q[k] = e_q[k-1];
            e_v[k] = e_v[k-1];
        end
        e_v[0] = v;
        e_i[0] = en ? mix(x, lo_sin((p + 256) % 1024)) : 0;
        e_q[0] = en ? mix(x, lo_sin(p)) : 0;
    endtask

    task automatic run(int n, int xbase, int xstep, int tagper, bit en);
        for (int i = 0; i < n; i++) begin
            int x = ((xbase + i * xstep) % 16384 + 16384) % 16384 - 8192;
            cyc(x, 1'b1, (tagper > 0) && (i % tagper == tagper - 1), 1'b0, en, 1'b0, 1'b0, 32'd0);
        end
    endtask

    task automatic wreg(bit ad, logic [31:0] d);
        cyc(0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, ad, d);
    endtask

    bit done = 1'b0;
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m_acc = 0; m_act = 0; m_word = 0; m_harm = 8'd1;
        for (int k = 0; k < 3; k++) begin e_i[k] = 0; e_q[k] = 0; e_v[k] = 1'b0; end
        repeat (4) @(posedge clk);
        @(negedge clk);
        cur_req = "R1";
        check("reset valid", int'(out_valid), 0);
        check("reset I", int'(i_out), 0);
        check("reset Q", int'(q_out), 0);
        rst_n = 1'b1;
        // R1: active step 0 after reset, phase stays at 0
        run(12, 5000, 0, 0, 1'b1);

        // R2: staged writes do not move the oscillator
        cur_req = "R2";
        wreg(1'b0, 32'h0140_0000);
        wreg(1'b1, 32'hFFFF_FF03);
        run(20, 7000, 0, 0, 1'b1);

        // R4 / R3 / R6: harmonic sweep with tags
        for (int h = 1; h <= 6; h++) begin
            cur_req = "R2";
            wreg(1'b0, 32'h0040_0000 + h * 32'h0001_3579);
            wreg(1'b1, h);
            run(5, 3000, 11, 0, 1'b1);
            cur_req = "R4";
            cyc(4000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'd0);
            cur_req = "R3";
            run(80, h * 101, 397, 37, 1'b1);
        end

        // R6 / R7: full-table sweep at extreme samples
        cur_req = "R7";
        wreg(1'b0, 32'h0040_0000);
        wreg(1'b1, 32'd1);
        cyc(-8192, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'd0);
        run(1024, 0, 0, 0, 1'b1);
        run(1024, 16383, 0, 0, 1'b1);
        cur_req = "R6";
        run(300, 123, 4099, 0, 1'b1);

        // R9: enable gating
        cur_req = "R9";
        for (int i = 0; i < 200; i++)
            cyc((i * 733) % 16384 - 8192, 1'b1, 1'b0, 1'b0, (i % 3) != 0, 1'b0, 1'b0, 32'd0);

        // R5: tag and double-tag together
        cur_req = "R5";
        wreg(1'b1, 32'd7);
        cyc(6000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'd0);
        run(50, 900, 211, 0, 1'b1);

        // R4: write in the commit cycle is not committed
        cur_req = "R4";
        wreg(1'b0, 32'h0023_4567);
        cyc(-3000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 32'd2);
        run(60, 400, 977, 0, 1'b1);
        cyc(-3000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'd0);
        run(60, 400, 977, 23, 1'b1);

        // R8 / R10: gaps in adc_valid while the phase keeps running
        cur_req = "R10";
        for (int i = 0; i < 200; i++)
            cyc((i * 1291) % 16384 - 8192, (i % 4) != 1, (i % 53) == 52, 1'b0, 1'b1, 1'b0, 1'b0, 32'd0);
        cur_req = "R8";
        for (int i = 0; i < 6; i++)
            cyc(0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule